// File: doc/BRIEF.md
# T1/E1 Line Transmit Encoder

This block is the transmit path of one channel of a T1/E1 line interface. It turns system-side NRZ data into a pair of pulse enables, one for positive and one for negative line pulses, which drive an external pulse shaper and line driver. The system pins are captured on the falling edge of the block clock. A bit strobe marks each system bit and advances the encoder by one bit. A separate master-reference strobe times the all-ones output.

In single-rail mode the data pin is AMI-encoded. Zero substitution can be turned on: B8ZS when the channel runs as T1, HDB3 when it runs as E1. While substitution is off, the negative pin, or a control input, can force a bipolar violation on a mark. In dual-rail mode the two system pins map straight to the two pulse enables and substitution is never applied. A maintenance override replaces the system data with an internally generated test bit. All-ones can be forced on command, or engaged automatically when the receiver reports loss of signal. A power-down input silences both outputs.

Every data path goes through one eight-bit lookahead buffer, so the output lags the data strobes by eight bits in every mode.

Top module: `txe_line_encoder`

## Requirements
- R1: After reset both pulse enables are low, the eight buffer slots hold spaces, and the first mark sent afterwards is positive.
- R2: `sys_pos`/`sys_neg` are sampled on the falling clock edge. On the rising edge that has `bit_stb` high, the outputs take the symbol of the bit captured eight strobes earlier (spaces for the first eight strobes after reset). The outputs hold their value on any edge with no active strobe.
- R3: In single-rail mode (`dual_rail`=0) with `code_sel`=0, a 1 gives a mark whose polarity is opposite to the previous mark, and a 0 gives no pulse. This holds for both line standards.
- R4: With single-rail, `std_e1`=0 and `code_sel`=1, each run of eight zeros is sent as 000VB0VB. V has the polarity of the preceding pulse, B has the opposite polarity, and the zero count restarts after each substitution.
- R5: With single-rail, `std_e1`=1 and `code_sel`=1, each run of four zeros is sent as B00V when an even number of marks (B pulses included) has passed since the last substitution, and as 000V when that number is odd. The count is even after reset.
- R6: In dual-rail mode `sys_pos` alone gives a positive pulse and `sys_neg` alone gives a negative pulse. Both high, or both low, gives no pulse. No substitution is applied, whatever `code_sel` says.
- R7: In single-rail mode with substitution off, a mark with `sys_neg` or `bpv_cmd` high is sent with the same polarity as the previous pulse, and the alternation tracker is left unchanged. With substitution on, both requests are ignored.
- R8: With `maint_en`=1 in single-rail mode, `maint_bit` replaces `sys_pos` as the data and `sys_neg` is ignored.
- R9: While `force_ones` is high, or `auto_ones_en` and `rx_los` are both high, each `mref_stb` sends a mark of alternating polarity, and `bit_stb` and the data pins have no effect. `rx_los` alone does nothing.
- R10: Leaving all-ones sends eight spaces first. The next mark continues the alternation from the last all-ones mark.
- R11: One edge after `pwr_down` is seen high, both outputs are low. Encoding and the polarity tracker keep running underneath.
- R12: `line_p` and `line_n` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the data pins are captured on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | System bit strobe, one per data bit |
| sys_pos | input | 1 | Single-rail data, or dual-rail positive data |
| sys_neg | input | 1 | Dual-rail negative data, or violation request in single-rail |
| mref_stb | input | 1 | Master-reference bit strobe used during all-ones |
| dual_rail | input | 1 | 1 selects dual-rail mode, 0 selects single-rail |
| std_e1 | input | 1 | 1 selects E1 (HDB3), 0 selects T1 (B8ZS) |
| code_sel | input | 1 | Enables zero substitution in single-rail mode |
| bpv_cmd | input | 1 | Control request to send the current mark as a violation |
| maint_en | input | 1 | Replaces system data with `maint_bit` |
| maint_bit | input | 1 | Test-pattern data bit |
| force_ones | input | 1 | Forces all-ones transmission |
| auto_ones_en | input | 1 | Allows loss of signal to engage all-ones |
| rx_los | input | 1 | Receiver loss-of-signal indication |
| pwr_down | input | 1 | Forces both outputs low |
| line_p | output | 1 | Positive pulse enable |
| line_n | output | 1 | Negative pulse enable |

## Verification
The assertions assume three things: configuration inputs change only while the channel is idle or in reset, the data and strobe inputs are steady around the falling edge, and `bit_stb` and `mref_stb` are single-cycle pulses relative to the clock. The stimulus meets these assumptions. Every input is driven a short delay after the rising edge, and the mode, standard and substitution settings are changed only after a fresh reset. Within a stream, the bit patterns are biased towards zeros so that runs of four, eight and longer occur often. Idle cycles are inserted between strobes, and power-down is toggled in blocks.

// File: rtl/txe_pkg.sv
package txe_pkg;

    // Symbol held in one lookahead slot; polarity is resolved at the output.
    typedef enum logic [2:0] {
        SYM_ZERO = 3'd0,  // no pulse
        SYM_MARK = 3'd1,  // pulse opposite to previous pulse
        SYM_VIOL = 3'd2,  // pulse equal to previous pulse
        SYM_POS  = 3'd3,  // explicit positive pulse (dual-rail)
        SYM_NEG  = 3'd4   // explicit negative pulse (dual-rail)
    } sym_t;

endpackage

// File: rtl/txe_capture.sv
module txe_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic pos_i,
    input  logic neg_i,
    output logic pos_o,
    output logic neg_o
);

    typedef struct packed {
        logic pos;
        logic neg;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d.pos = pos_i;
        cap_d.neg = neg_i;
    end

    // system data is taken on the falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign pos_o = cap_q.pos;
    assign neg_o = cap_q.neg;

endmodule

// File: rtl/txe_classify.sv
module txe_classify
    import txe_pkg::*;
(
    input  logic pos_i,
    input  logic neg_i,
    input  logic dual_i,
    input  logic code_sel_i,
    input  logic bpv_cmd_i,
    input  logic maint_en_i,
    input  logic maint_bit_i,
    output sym_t sym_o,
    output logic subst_o
);

    logic subst;
    logic data_bit;
    logic bpv_req;

    always_comb begin
        subst    = !dual_i && code_sel_i;
        data_bit = maint_en_i ? maint_bit_i : pos_i;
        bpv_req  = ((!maint_en_i && neg_i) || bpv_cmd_i) && !subst;
        sym_o    = SYM_ZERO;
        if (dual_i) begin
            if (pos_i && !neg_i)      sym_o = SYM_POS;
            else if (neg_i && !pos_i) sym_o = SYM_NEG;
        end else if (data_bit) begin
            sym_o = bpv_req ? SYM_VIOL : SYM_MARK;
        end
    end

    assign subst_o = subst;

endmodule

// File: rtl/txe_subst_buf.sv
module txe_subst_buf
    import txe_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int RUN_T1 = 8,
    parameter int RUN_E1 = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_i,
    input  logic clear_i,
    input  logic subst_i,
    input  logic std_e1_i,
    input  sym_t sym_i,
    output sym_t sym_o
);

    localparam int CW = $clog2(RUN_T1 + 1);
    // positions inside the run, counted from the newest slot
    localparam int T1_V_OLD = RUN_T1 - 4;
    localparam int T1_B_OLD = RUN_T1 - 5;
    localparam int T1_V_NEW = RUN_T1 - 7;
    localparam int T1_B_NEW = RUN_T1 - 8;
    localparam int E1_B     = RUN_E1 - 1;

    typedef struct packed {
        sym_t [DEPTH-1:0] slots;
        logic [CW-1:0]    run;
        logic             odd;
    } buf_t;

    buf_t buf_d, buf_q;
    logic [CW-1:0] lim;
    logic [CW-1:0] run_nx;

    always_comb begin
        buf_d  = buf_q;
        lim    = std_e1_i ? CW'(RUN_E1) : CW'(RUN_T1);
        run_nx = buf_q.run + 1'b1;
        if (clear_i) begin
            for (int i = 0; i < DEPTH; i++) buf_d.slots[i] = SYM_ZERO;
            buf_d.run = '0;
        end else if (adv_i) begin
            for (int i = DEPTH - 1; i > 0; i--) buf_d.slots[i] = buf_q.slots[i-1];
            buf_d.slots[0] = sym_i;
            if (sym_i == SYM_MARK) buf_d.odd = ~buf_q.odd;
            if (!subst_i || sym_i != SYM_ZERO) begin
                buf_d.run = '0;
            end else if (run_nx == lim) begin
                buf_d.run = '0;
                if (std_e1_i) begin
                    if (!buf_q.odd) buf_d.slots[E1_B] = SYM_MARK;
                    buf_d.slots[0] = SYM_VIOL;
                    buf_d.odd      = 1'b0;
                end else begin
                    buf_d.slots[T1_V_OLD] = SYM_VIOL;
                    buf_d.slots[T1_B_OLD] = SYM_MARK;
                    buf_d.slots[T1_V_NEW] = SYM_VIOL;
                    buf_d.slots[T1_B_NEW] = SYM_MARK;
                end
            end else begin
                buf_d.run = run_nx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign sym_o = buf_q.slots[DEPTH-1];

    // R4
    run_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_q.run < CW'(RUN_T1));

    // R10
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> ($countones(buf_q.slots) == 0));

endmodule

// File: rtl/txe_pulse_out.sv
module txe_pulse_out
    import txe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic data_adv_i,
    input  logic ones_adv_i,
    input  logic pwr_down_i,
    input  sym_t sym_i,
    output logic p_o,
    output logic n_o
);

    typedef struct packed {
        logic p;
        logic n;
        logic last_pos;
    } out_t;

    out_t out_d, out_q;
    logic pp, nn;

    always_comb begin
        out_d = out_q;
        pp    = out_q.p;
        nn    = out_q.n;
        if (ones_adv_i) begin
            pp             = ~out_q.last_pos;
            nn             = out_q.last_pos;
            out_d.last_pos = ~out_q.last_pos;
        end else if (data_adv_i) begin
            case (sym_i)
                SYM_MARK: begin
                    pp             = ~out_q.last_pos;
                    nn             = out_q.last_pos;
                    out_d.last_pos = ~out_q.last_pos;
                end
                SYM_VIOL: begin
                    pp = out_q.last_pos;
                    nn = ~out_q.last_pos;
                end
                SYM_POS: begin
                    pp             = 1'b1;
                    nn             = 1'b0;
                    out_d.last_pos = 1'b1;
                end
                SYM_NEG: begin
                    pp             = 1'b0;
                    nn             = 1'b1;
                    out_d.last_pos = 1'b0;
                end
                default: begin
                    pp = 1'b0;
                    nn = 1'b0;
                end
            endcase
        end
        out_d.p = pp & ~pwr_down_i;
        out_d.n = nn & ~pwr_down_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign p_o = out_q.p;
    assign n_o = out_q.n;

    // R12
    never_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(p_o && n_o));

    // R11
    pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down_i |=> (!p_o && !n_o));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_adv_i && !ones_adv_i && !pwr_down_i) |=> ($stable(p_o) && $stable(n_o)));

    // R9
    ones_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ones_adv_i && !pwr_down_i) |=> (p_o != n_o));

endmodule

// File: rtl/txe_line_encoder.sv
module txe_line_encoder
    import txe_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int RUN_T1 = 8,
    parameter int RUN_E1 = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_stb,
    input  logic sys_pos,
    input  logic sys_neg,
    input  logic mref_stb,
    input  logic dual_rail,
    input  logic std_e1,
    input  logic code_sel,
    input  logic bpv_cmd,
    input  logic maint_en,
    input  logic maint_bit,
    input  logic force_ones,
    input  logic auto_ones_en,
    input  logic rx_los,
    input  logic pwr_down,
    output logic line_p,
    output logic line_n
);

    logic cap_pos, cap_neg;
    logic ones_mode, data_adv, ones_adv, subst;
    sym_t in_sym, out_sym;

    assign ones_mode = force_ones || (auto_ones_en && rx_los);
    assign data_adv  = bit_stb && !ones_mode;
    assign ones_adv  = mref_stb && ones_mode;

    txe_capture cap_i (
        .clk   (clk),
        .rst_n (rst_n),
        .pos_i (sys_pos),
        .neg_i (sys_neg),
        .pos_o (cap_pos),
        .neg_o (cap_neg)
    );

    txe_classify cls_i (
        .pos_i       (cap_pos),
        .neg_i       (cap_neg),
        .dual_i      (dual_rail),
        .code_sel_i  (code_sel),
        .bpv_cmd_i   (bpv_cmd),
        .maint_en_i  (maint_en),
        .maint_bit_i (maint_bit),
        .sym_o       (in_sym),
        .subst_o     (subst)
    );

    txe_subst_buf #(
        .DEPTH  (DEPTH),
        .RUN_T1 (RUN_T1),
        .RUN_E1 (RUN_E1)
    ) buf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv_i    (data_adv),
        .clear_i  (ones_mode),
        .subst_i  (subst),
        .std_e1_i (std_e1),
        .sym_i    (in_sym),
        .sym_o    (out_sym)
    );

    txe_pulse_out out_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_adv_i (data_adv),
        .ones_adv_i (ones_adv),
        .pwr_down_i (pwr_down),
        .sym_i      (out_sym),
        .p_o        (line_p),
        .n_o        (line_n)
    );

endmodule

// File: tb/txe_line_encoder_tb.sv
module txe_line_encoder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LAT = 8;
    localparam int MAXN = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_stb = 0, sys_pos = 0, sys_neg = 0, mref_stb = 0;
    logic dual_rail = 0, std_e1 = 0, code_sel = 0, bpv_cmd = 0;
    logic maint_en = 0, maint_bit = 0, force_ones = 0, auto_ones_en = 0;
    logic rx_los = 0, pwr_down = 0;
    logic line_p, line_n;

    int n_tests = 0;
    int n_fail = 0;
    logic [15:0] lfsr = 16'hACE1;

    int a_p[MAXN], a_n[MAXN], a_cmd[MAXN], a_mb[MAXN], a_pd[MAXN], a_gap[MAXN];
    int e_sym[MAXN], e_p[MAXN], e_n[MAXN];

    always #(CLK_PERIOD/2) clk = ~clk;

    txe_line_encoder dut_i (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .sys_pos(sys_pos),
        .sys_neg(sys_neg), .mref_stb(mref_stb), .dual_rail(dual_rail),
        .std_e1(std_e1), .code_sel(code_sel), .bpv_cmd(bpv_cmd),
        .maint_en(maint_en), .maint_bit(maint_bit), .force_ones(force_ones),
        .auto_ones_en(auto_ones_en), .rx_los(rx_los), .pwr_down(pwr_down),
        .line_p(line_p), .line_n(line_n)
    );

    function automatic int rbit();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return int'(lfsr[0]);
    endfunction

    task automatic chk(input string req, input logic ep, input logic en);
        n_tests++;
        if (line_p !== ep || line_n !== en) begin
            n_fail++;
            $display("FAIL %s: got p=%0b n=%0b expected p=%0b n=%0b", req, line_p, line_n, ep, en);
        end
        n_tests++;
        if (line_p === 1'b1 && line_n === 1'b1) begin
            n_fail++;
            $display("FAIL R12: got p=1 n=1 expected at most one high");
        end
    endtask

    // every task returns 2 time units after a rising edge
    task automatic do_reset();
        rst_n = 0; bit_stb = 0; mref_stb = 0; sys_pos = 0; sys_neg = 0;
        bpv_cmd = 0; pwr_down = 0; force_ones = 0; auto_ones_en = 0; rx_los = 0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
    endtask

    task automatic step(input logic bs, input logic ms, input logic p, input logic n);
        bit_stb = bs; mref_stb = ms; sys_pos = p; sys_neg = n;
        @(posedge clk);
        #2;
        bit_stb = 0; mref_stb = 0;
    endtask

    // expected symbols: 0 space, 1 alternating mark, 2 repeat-polarity, 3 pos, 4 neg
    task automatic build_expected(input int n);
        int run, odd, lim, last;
        logic subst;
        subst = !dual_rail && code_sel;
        lim = std_e1 ? 4 : 8;
        for (int i = 0; i < n; i++) begin
            if (dual_rail) begin
                e_sym[i] = (a_p[i] == 1 && a_n[i] == 0) ? 3 : (a_n[i] == 1 && a_p[i] == 0) ? 4 : 0;
            end else begin
                int d, v;
                d = maint_en ? a_mb[i] : a_p[i];
                v = (((!maint_en && a_n[i] == 1) || a_cmd[i] == 1) && !subst) ? 1 : 0;
                e_sym[i] = (d == 0) ? 0 : (v == 1 ? 2 : 1);
            end
        end
        run = 0; odd = 0;
        for (int i = 0; i < n; i++) begin
            if (e_sym[i] == 1) odd ^= 1;
            if (!subst || e_sym[i] != 0) run = 0;
            else begin
                run++;
                if (run == lim) begin
                    run = 0;
                    if (std_e1) begin
                        if (odd == 0) e_sym[i-3] = 1;
                        e_sym[i] = 2;
                        odd = 0;
                    end else begin
                        e_sym[i-4] = 2; e_sym[i-3] = 1; e_sym[i-1] = 2; e_sym[i] = 1;
                    end
                end
            end
        end
        last = 0;
        for (int i = 0; i < n; i++) begin
            case (e_sym[i])
                1: begin e_p[i] = 1 - last; e_n[i] = last; last = 1 - last; end
                2: begin e_p[i] = last; e_n[i] = 1 - last; end
                3: begin e_p[i] = 1; e_n[i] = 0; last = 1; end
                4: begin e_p[i] = 0; e_n[i] = 1; last = 0; end
                default: begin e_p[i] = 0; e_n[i] = 0; end
            endcase
        end
    endtask

    task automatic run_stream(input int n, input string req);
        logic hp, hn;
        build_expected(n);
        do_reset();
        for (int k = 0; k < n; k++) begin
            bpv_cmd = a_cmd[k][0]; maint_bit = a_mb[k][0]; pwr_down = a_pd[k][0];
            step(1'b1, 1'b0, a_p[k][0], a_n[k][0]);
            hp = (k < LAT || a_pd[k] == 1) ? 1'b0 : e_p[k-LAT][0];
            hn = (k < LAT || a_pd[k] == 1) ? 1'b0 : e_n[k-LAT][0];
            chk($sformatf("%s strobe %0d", req, k), hp, hn);
            if (a_gap[k] == 1) begin
                bpv_cmd = 0; pwr_down = 0;
                step(1'b0, 1'b0, 1'b0, 1'b0);
                chk($sformatf("R2 hold after %s strobe %0d", req, k), hp, hn);
            end
        end
        bpv_cmd = 0; pwr_down = 0;
    endtask

    task automatic fill(input int n, input int want_n, input int want_cmd,
                        input int want_mb, input int want_pd);
        int pdrun;
        pdrun = 0;
        for (int i = 0; i < n; i++) begin
            a_p[i]   = rbit() & rbit();
            a_n[i]   = want_n   != 0 ? (rbit() & rbit()) : 0;
            a_cmd[i] = want_cmd != 0 ? (rbit() & rbit() & rbit()) : 0;
            a_mb[i]  = want_mb  != 0 ? rbit() : 0;
            a_gap[i] = rbit() & rbit() & rbit();
            if (want_pd != 0 && pdrun == 0 && (rbit() & rbit() & rbit()) == 1) pdrun = 5;
            a_pd[i] = (pdrun > 0) ? 1 : 0;
            if (pdrun > 0) pdrun--;
        end
        // guarantee a long zero run early in the stream
        for (int i = 20; i < 37; i++) a_p[i] = 0;
        a_p[19] = 1;
    endtask

    task automatic set_cfg(input logic dr, input logic e1, input logic cs, input logic me);
        dual_rail = dr; std_e1 = e1; code_sel = cs; maint_en = me;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        do_reset();
        // R1: reset state
        chk("R1 reset outputs", 1'b0, 1'b0);

        // R3: AMI, both standards
        for (int s = 0; s < 2; s++) begin
            set_cfg(0, s[0], 0, 0); fill(200, 0, 0, 0, 0);
            run_stream(200, "R3 AMI");
        end
        // R4: B8ZS
        for (int s = 0; s < 2; s++) begin
            set_cfg(0, 0, 1, 0); fill(200, 0, 0, 0, 0);
            run_stream(200, "R4 B8ZS");
        end
        // R5: HDB3
        for (int s = 0; s < 2; s++) begin
            set_cfg(0, 1, 1, 0); fill(200, 0, 0, 0, 0);
            run_stream(200, "R5 HDB3");
        end
        // R6: dual-rail, substitution requested but not applied
        for (int s = 0; s < 2; s++) begin
            set_cfg(1, s[0], 1, 0); fill(200, 1, 0, 0, 0);
            for (int i = 0; i < 200; i++) if (i % 7 == 0) begin a_p[i] = 1; a_n[i] = 1; end
            run_stream(200, "R6 dual");
        end
        // R7: violations through pin and control input, then ignored with substitution
        set_cfg(0, 0, 0, 0); fill(200, 1, 0, 0, 0); run_stream(200, "R7 bpv pin");
        set_cfg(0, 1, 0, 0); fill(200, 0, 1, 0, 0); run_stream(200, "R7 bpv cmd");
        set_cfg(0, 0, 1, 0); fill(200, 1, 1, 0, 0); run_stream(200, "R7 bpv ignored B8ZS");
        set_cfg(0, 1, 1, 0); fill(200, 1, 1, 0, 0); run_stream(200, "R7 bpv ignored HDB3");
        // R8: maintenance override
        set_cfg(0, 0, 0, 1); fill(200, 1, 0, 1, 0); run_stream(200, "R8 maint");
        // R11: power-down blocks
        set_cfg(0, 0, 1, 0); fill(200, 0, 0, 0, 1); run_stream(200, "R11 pwr_down");
        set_cfg(0, 0, 0, 0);

        // R9: forced all-ones, data ignored between master strobes
        do_reset();
        force_ones = 1;
        for (int m = 0; m < 6; m++) begin
            step(1'b1, 1'b1, rbit()[0], rbit()[0]);
            chk($sformatf("R9 forced tick %0d", m), (m % 2 == 0), (m % 2 == 1));
            step(1'b1, 1'b0, 1'b1, 1'b0);
            chk($sformatf("R9 data ignored %0d", m), (m % 2 == 0), (m % 2 == 1));
        end
        force_ones = 0;

        // R9: automatic engagement on loss of signal
        do_reset();
        auto_ones_en = 1; rx_los = 1;
        step(1'b0, 1'b1, 1'b0, 1'b0); chk("R9 auto tick 0", 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b0, 1'b0); chk("R9 auto tick 1", 1'b0, 1'b1);
        do_reset();
        auto_ones_en = 1; rx_los = 0;
        step(1'b0, 1'b1, 1'b0, 1'b0); chk("R9 auto without los", 1'b0, 1'b0);
        auto_ones_en = 0; rx_los = 1;
        step(1'b0, 1'b1, 1'b0, 1'b0); chk("R9 los without enable", 1'b0, 1'b0);
        rx_los = 0;

        // R10: exit from all-ones after three marks (last mark positive)
        do_reset();
        force_ones = 1;
        for (int m = 0; m < 3; m++) step(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R10 last all-ones mark", 1'b1, 1'b0);
        force_ones = 0;
        for (int k = 0; k < LAT; k++) begin
            step(1'b1, 1'b0, 1'b1, 1'b0);
            chk($sformatf("R10 flush strobe %0d", k), 1'b0, 1'b0);
        end
        step(1'b1, 1'b0, 1'b1, 1'b0);
        chk("R10 first data mark alternates", 1'b0, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule